// File: doc/BRIEF.md
# Pause Frame Receive Controller

The block watches the received Ethernet byte stream for MAC control pause frames and holds off the transmit path for as long as each one asks. Each frame arrives one byte per accepted beat, with a start-of-frame mark on the first byte and an end-of-frame mark on the last. A frame-good flag comes with the last byte and carries the CRC and length verdict made upstream. The block never applies back-pressure. `rx_ready` is tied high, and every cycle in which `rx_valid` is high transfers one byte. A cycle with `rx_valid` low transfers nothing, and the stream can pause between any two bytes.

A valid pause frame loads its 16-bit pause time into a quanta counter. A free-running single-cycle strobe counts the counter down, one step per 512-bit-time quantum. While the counter is non-zero, the transmitter is refused permission to start a new frame. A frame that is already on the wire is never cut short. A pause frame received during an active pause replaces the remaining count at once, and a pause time of zero ends the pause immediately. For every good control frame the block also reports whether it should be forwarded to the application or filtered out, according to a policy input.

Top module: `pfc_rx_ctrl`

## Requirements
- R1: While `cfg_fc_en` is low, no pause frame changes the counter. The counter reads 0 from the cycle after `cfg_fc_en` falls, `pause_active` stays low and `ctl_valid` never pulses.
- R2: A frame counts as a pause frame only if all of the following hold:
  - the type (bytes 12-13, most significant byte first) is 0x8808;
  - the opcode (bytes 14-15) is 0x0001;
  - the destination (bytes 0-5, first byte first) is 01-80-C2-00-00-01, or equals `cfg_station_addr` (bits 47:40 = byte 0) while `cfg_uc_en` is high.

  Any other frame leaves the counter unchanged.
- R3: A valid pause frame loads its pause time into the counter. The pause time is bytes 16-17, big-endian. The new value appears on `pause_count` two clock cycles after the cycle that accepts the end-of-frame byte. `pause_active` is high exactly while `pause_count` is non-zero.
- R4: A valid pause frame arriving while a pause is already running replaces the remaining count with its own value, whether that value is larger or smaller.
- R5: A valid pause frame with pause time 0 clears the counter and drops `pause_active` at the same point where a load would take effect.
- R6: Each `quanta_tick` strobe lowers a non-zero counter by one. The counter never goes below zero, and it does not change in a cycle without a tick or a load. When a load and a tick fall in the same cycle, the load wins.
- R7: A frame changes nothing unless `rx_good` is high with its end-of-frame byte. A frame that ends before byte 17 changes nothing either.
- R8: One cycle after the end-of-frame byte of a good frame with type 0x8808 and at least 14 bytes, while enabled, `ctl_valid` pulses for one cycle. In that cycle `ctl_drop` is high if `cfg_ctl_pass` is 0 (filter) and low if it is 1 (forward). `ctl_valid` never pulses for a frame of any other type.
- R9: `tx_start_gnt` is high only when `tx_start_req` is high, `tx_busy` is low and `pause_active` is low. A pause never affects a frame already in flight (`tx_busy` high). It only withholds the next grant.
- R10: `rx_ready` is high in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Always high: the block accepts every byte |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_good | input | 1 | Frame passed CRC and length checks (valid with rx_eof) |
| cfg_fc_en | input | 1 | Receive flow control enable |
| cfg_uc_en | input | 1 | Also accept pause frames sent to the station address |
| cfg_station_addr | input | 48 | Station unicast address, byte 0 in bits 47:40 |
| cfg_ctl_pass | input | 1 | 1 forwards control frames, 0 filters them |
| quanta_tick | input | 1 | One-cycle strobe per pause quantum |
| tx_start_req | input | 1 | Transmitter wants to start a frame |
| tx_busy | input | 1 | Transmitter is in the middle of a frame |
| tx_start_gnt | output | 1 | Permission to start a frame |
| pause_active | output | 1 | Transmit pause in force |
| pause_count | output | 16 | Remaining pause quanta |
| ctl_valid | output | 1 | Control-frame decision strobe |
| ctl_drop | output | 1 | Decision: 1 drop, 0 forward |

## Verification
The assertions take for granted a well-formed input stream:
- `rx_sof` marks the first accepted byte of each frame;
- `rx_eof` closes every frame;
- `rx_good` is only meaningful on the closing byte;
- `quanta_tick` is a single-cycle strobe.

The directed stimulus meets these assumptions in every case. Each frame is built byte by byte from its destination, type, opcode and pause time. The only deviations injected are the ones the requirements name: a cleared good flag, a frame truncated before the pause time, a wrong opcode, a unicast destination and a non-control type. Configuration inputs change only between frames.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int PT_W = 16;
  localparam logic [15:0] CTL_ETYPE   = 16'h8808;
  localparam logic [15:0] OPC_PAUSE   = 16'h0001;
  localparam logic [47:0] PAUSE_GROUP = 48'h0180C2000001;
  localparam int ADDR_BYTES = 6;
  localparam int TYPE_HI    = 12;
  localparam int OPC_HI     = 14;
  localparam int PT_HI      = 16;
  localparam int PT_LO      = 17;
  typedef logic [PT_W-1:0] quanta_t;
endpackage

// File: rtl/pfc_parser.sv
module pfc_parser
  import pfc_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic        rx_good,
  input  logic        cfg_fc_en,
  input  logic        cfg_uc_en,
  input  logic [47:0] cfg_station_addr,
  output logic        ev_ctl,
  output logic        ev_pause,
  output quanta_t     ev_time
);
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

  logic [IDX_W-1:0] idx_q, cur_idx;
  logic             mc_q, uc_q, mc_n, uc_n;
  logic [15:0]      type_q, opc_q, type_n, opc_n;
  quanta_t          pt_q, pt_n;

  function automatic logic [7:0] addr_byte(input logic [47:0] a, input logic [IDX_W-1:0] i);
    addr_byte = 8'h00;
    for (int k = 0; k < ADDR_BYTES; k++)
      if (i == IDX_W'(k)) addr_byte = a[47-8*k -: 8];
  endfunction

  always_comb begin
    cur_idx = rx_sof ? '0 : idx_q;
    mc_n    = (cur_idx == '0) ? 1'b1 : mc_q;
    uc_n    = (cur_idx == '0) ? 1'b1 : uc_q;
    if (cur_idx < IDX_W'(ADDR_BYTES)) begin
      mc_n = mc_n & (rx_data == addr_byte(PAUSE_GROUP, cur_idx));
      uc_n = uc_n & (rx_data == addr_byte(cfg_station_addr, cur_idx));
    end
    type_n = type_q;
    opc_n  = opc_q;
    pt_n   = pt_q;
    if (cur_idx == IDX_W'(TYPE_HI) || cur_idx == IDX_W'(TYPE_HI+1)) type_n = {type_q[7:0], rx_data};
    if (cur_idx == IDX_W'(OPC_HI)  || cur_idx == IDX_W'(OPC_HI+1))  opc_n  = {opc_q[7:0], rx_data};
    if (cur_idx == IDX_W'(PT_HI)   || cur_idx == IDX_W'(PT_LO))     pt_n   = {pt_q[7:0], rx_data};
  end

  logic is_ctl, is_pause;
  always_comb begin
    is_ctl   = rx_good && cfg_fc_en && (cur_idx >= IDX_W'(TYPE_HI+1)) && (type_n == CTL_ETYPE);
    is_pause = is_ctl && (cur_idx >= IDX_W'(PT_LO)) && (opc_n == OPC_PAUSE) &&
               (mc_n || (cfg_uc_en && uc_n));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q    <= '0;
      mc_q     <= 1'b0;
      uc_q     <= 1'b0;
      type_q   <= '0;
      opc_q    <= '0;
      pt_q     <= '0;
      ev_ctl   <= 1'b0;
      ev_pause <= 1'b0;
      ev_time  <= '0;
    end else begin
      ev_ctl   <= 1'b0;
      ev_pause <= 1'b0;
      if (rx_valid) begin
        mc_q   <= mc_n;
        uc_q   <= uc_n;
        type_q <= type_n;
        opc_q  <= opc_n;
        pt_q   <= pt_n;
        if (rx_eof) begin
          idx_q    <= '0;
          ev_ctl   <= is_ctl;
          ev_pause <= is_pause;
          ev_time  <= pt_n;
        end else begin
          idx_q <= (cur_idx == IDX_MAX) ? IDX_MAX : cur_idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pfc_quanta_cnt.sv
module pfc_quanta_cnt
  import pfc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en,
  input  logic    load,
  input  quanta_t load_val,
  input  logic    tick,
  output quanta_t count,
  output logic    active
);
  always_ff @(posedge clk) begin
    if (!rst_n || !en)            count <= '0;
    else if (load)                count <= load_val;
    else if (tick && count != '0) count <= count - 1'b1;
  end

  assign active = (count != '0);
endmodule

// File: rtl/pfc_tx_gate.sv
module pfc_tx_gate (
  input  logic req,
  input  logic busy,
  input  logic pause,
  output logic gnt
);
  assign gnt = req && !busy && !pause;
endmodule

// File: rtl/pfc_rx_ctrl.sv
module pfc_rx_ctrl
  import pfc_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic        rx_good,
  input  logic        cfg_fc_en,
  input  logic        cfg_uc_en,
  input  logic [47:0] cfg_station_addr,
  input  logic        cfg_ctl_pass,
  input  logic        quanta_tick,
  input  logic        tx_start_req,
  input  logic        tx_busy,
  output logic        tx_start_gnt,
  output logic        pause_active,
  output logic [15:0] pause_count,
  output logic        ctl_valid,
  output logic        ctl_drop
);
  logic    ev_ctl, ev_pause;
  quanta_t ev_time, cnt;

  assign rx_ready = 1'b1;

  pfc_parser #(.IDX_W(IDX_W)) u_parse (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_good(rx_good),
    .cfg_fc_en(cfg_fc_en), .cfg_uc_en(cfg_uc_en), .cfg_station_addr(cfg_station_addr),
    .ev_ctl(ev_ctl), .ev_pause(ev_pause), .ev_time(ev_time)
  );

  pfc_quanta_cnt u_cnt (
    .clk(clk), .rst_n(rst_n), .en(cfg_fc_en), .load(ev_pause), .load_val(ev_time),
    .tick(quanta_tick), .count(cnt), .active(pause_active)
  );

  pfc_tx_gate u_gate (
    .req(tx_start_req), .busy(tx_busy), .pause(pause_active), .gnt(tx_start_gnt)
  );

  assign pause_count = cnt;
  assign ctl_valid   = ev_ctl && cfg_fc_en;
  assign ctl_drop    = ctl_valid && !cfg_ctl_pass;
endmodule

// File: rtl/pfc_rx_ctrl_chk.sv
module pfc_rx_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_ready,
  input logic        cfg_fc_en,
  input logic        quanta_tick,
  input logic        tx_start_req,
  input logic        tx_busy,
  input logic        tx_start_gnt,
  input logic        pause_active,
  input logic [15:0] pause_count,
  input logic        ctl_valid,
  input logic        ctl_drop,
  input logic        cfg_ctl_pass,
  input logic        ev_pause,
  input logic [15:0] ev_time
);
  p_off_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_fc_en |=> (pause_count == 16'd0));
  p_off_no_ctl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid |-> cfg_fc_en);
  p_load_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pause && cfg_fc_en) |=> (pause_count == $past(ev_time)));
  p_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pause_active == (pause_count != 16'd0));
  p_step_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fc_en && !ev_pause && quanta_tick && pause_count != 16'd0)
      |=> (pause_count == $past(pause_count) - 16'd1));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fc_en && !ev_pause && !quanta_tick) |=> $stable(pause_count));
  p_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start_gnt |-> (tx_start_req && !tx_busy && !pause_active));
  p_policy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_drop |-> (ctl_valid && !cfg_ctl_pass));
  p_ctl_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid |=> !ctl_valid);
  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready);
endmodule

bind pfc_rx_ctrl pfc_rx_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .cfg_fc_en(cfg_fc_en),
  .quanta_tick(quanta_tick), .tx_start_req(tx_start_req), .tx_busy(tx_busy),
  .tx_start_gnt(tx_start_gnt), .pause_active(pause_active), .pause_count(pause_count),
  .ctl_valid(ctl_valid), .ctl_drop(ctl_drop), .cfg_ctl_pass(cfg_ctl_pass),
  .ev_pause(ev_pause), .ev_time(ev_time)
);

// File: tb/test_pfc_rx_ctrl.sv
`timescale 1ns/1ps
module test_pfc_rx_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_good = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic cfg_fc_en = 1'b1, cfg_uc_en = 1'b0, cfg_ctl_pass = 1'b0;
  logic [47:0] cfg_station_addr = 48'h02A0B0C0D0E0;
  logic quanta_tick = 1'b0, tx_start_req = 1'b0, tx_busy = 1'b0;
  logic rx_ready, tx_start_gnt, pause_active, ctl_valid, ctl_drop;
  logic [15:0] pause_count;

  localparam logic [47:0] GRP = 48'h0180C2000001;
  localparam logic [47:0] SRC = 48'h020000000055;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic seen_cv, seen_cd;

  always #4 clk = ~clk;

  pfc_rx_ctrl i_pfc_rx_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_good(rx_good), .cfg_fc_en(cfg_fc_en),
    .cfg_uc_en(cfg_uc_en), .cfg_station_addr(cfg_station_addr), .cfg_ctl_pass(cfg_ctl_pass),
    .quanta_tick(quanta_tick), .tx_start_req(tx_start_req), .tx_busy(tx_busy),
    .tx_start_gnt(tx_start_gnt), .pause_active(pause_active), .pause_count(pause_count),
    .ctl_valid(ctl_valid), .ctl_drop(ctl_drop)
  );

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input int i, input logic [47:0] da,
                                       input logic [15:0] ty, input logic [15:0] op,
                                       input logic [15:0] pt);
    if (i < 6)       return da[47-8*i -: 8];
    else if (i < 12) return SRC[47-8*(i-6) -: 8];
    else if (i == 12) return ty[15:8];
    else if (i == 13) return ty[7:0];
    else if (i == 14) return op[15:8];
    else if (i == 15) return op[7:0];
    else if (i == 16) return pt[15:8];
    else if (i == 17) return pt[7:0];
    return 8'h00;
  endfunction

  // Starts and ends at a falling edge; pause_count is current on return.
  task automatic send(input logic [47:0] da, input logic [15:0] ty, input logic [15:0] op,
                      input logic [15:0] pt, input int len, input bit good);
    for (int i = 0; i < len; i++) begin
      rx_valid = 1'b1;
      rx_data  = fbyte(i, da, ty, op, pt);
      rx_sof   = (i == 0);
      rx_eof   = (i == len - 1);
      rx_good  = good && (i == len - 1);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_good = 1'b0;
    seen_cv = ctl_valid;
    seen_cd = ctl_drop;
    @(negedge clk);
  endtask

  task automatic tick();
    quanta_tick = 1'b1;
    @(negedge clk);
    quanta_tick = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 ready", rx_ready, 1);
    chk("R3 reset count", pause_count, 0);
    chk("R3 reset active", pause_active, 0);
    chk("R8 reset ctl", ctl_valid, 0);
  endtask

  task automatic t_basic_load();
    send(GRP, 16'h8808, 16'h0001, 16'd5, 64, 1);
    chk("R8 ctl strobe", seen_cv, 1);
    chk("R8 filter drop", seen_cd, 1);
    chk("R3 loaded", pause_count, 5);
    chk("R3 active", pause_active, 1);
    chk("R8 strobe one cycle", ctl_valid, 0);
  endtask

  task automatic t_countdown();
    for (int k = 0; k < 3; k++) tick();
    chk("R6 three ticks", pause_count, 2);
    repeat (4) @(negedge clk);
    chk("R6 no tick hold", pause_count, 2);
    for (int k = 0; k < 3; k++) tick();
    chk("R6 floor zero", pause_count, 0);
    chk("R3 inactive at zero", pause_active, 0);
  endtask

  task automatic t_reload();
    send(GRP, 16'h8808, 16'h0001, 16'd9, 60, 1);
    tick();
    chk("R4 running", pause_count, 8);
    send(GRP, 16'h8808, 16'h0001, 16'h0100, 60, 1);
    chk("R4 reload up", pause_count, 16'h0100);
    send(GRP, 16'h8808, 16'h0001, 16'd3, 60, 1);
    chk("R4 reload down", pause_count, 3);
  endtask

  task automatic t_zero();
    send(GRP, 16'h8808, 16'h0001, 16'd0, 60, 1);
    chk("R5 zero clears", pause_count, 0);
    chk("R5 resume", pause_active, 0);
  endtask

  task automatic t_rejects();
    send(GRP, 16'h8808, 16'h0001, 16'd7, 60, 0);
    chk("R7 bad frame", pause_count, 0);
    chk("R7 bad frame no ctl", seen_cv, 0);
    send(GRP, 16'h8808, 16'h0001, 16'd7, 17, 1);
    chk("R7 truncated", pause_count, 0);
    cfg_ctl_pass = 1'b1;
    send(GRP, 16'h8808, 16'h0002, 16'd7, 60, 1);
    chk("R2 wrong opcode", pause_count, 0);
    chk("R8 ctl other opcode", seen_cv, 1);
    chk("R8 forward", seen_cd, 0);
    send(GRP, 16'h0800, 16'h0001, 16'd7, 60, 1);
    chk("R2 wrong type", pause_count, 0);
    chk("R8 no ctl for data", seen_cv, 0);
    send(48'h0180C2000002, 16'h8808, 16'h0001, 16'd7, 60, 1);
    chk("R2 wrong group", pause_count, 0);
    cfg_ctl_pass = 1'b0;
  endtask

  task automatic t_unicast();
    send(cfg_station_addr, 16'h8808, 16'h0001, 16'd4, 60, 1);
    chk("R2 unicast off", pause_count, 0);
    cfg_uc_en = 1'b1;
    send(cfg_station_addr, 16'h8808, 16'h0001, 16'd4, 60, 1);
    chk("R2 unicast on", pause_count, 4);
    send(GRP, 16'h8808, 16'h0001, 16'd0, 60, 1);
    cfg_uc_en = 1'b0;
  endtask

  task automatic t_disable();
    send(GRP, 16'h8808, 16'h0001, 16'd6, 60, 1);
    cfg_fc_en = 1'b0;
    @(negedge clk);
    chk("R1 disable clears", pause_count, 0);
    send(GRP, 16'h8808, 16'h0001, 16'd6, 60, 1);
    chk("R1 ignored frame", pause_count, 0);
    chk("R1 no ctl", seen_cv, 0);
    chk("R1 no pause", pause_active, 0);
    cfg_fc_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_tx_gate();
    tx_start_req = 1'b1;
    tx_busy = 1'b0;
    @(negedge clk);
    chk("R9 grant idle", tx_start_gnt, 1);
    tx_busy = 1'b1;
    send(GRP, 16'h8808, 16'h0001, 16'd2, 60, 1);
    chk("R9 busy frame no grant", tx_start_gnt, 0);
    tx_busy = 1'b0;
    @(negedge clk);
    chk("R9 paused no grant", tx_start_gnt, 0);
    tick();
    tick();
    chk("R9 grant after pause", tx_start_gnt, 1);
    tx_start_req = 1'b0;
    @(negedge clk);
    chk("R9 no request", tx_start_gnt, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_load();
    t_countdown();
    t_reload();
    t_zero();
    t_rejects();
    t_unicast();
    t_disable();
    t_tx_gate();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule